// File: doc/BRIEF.md
# Four-Channel Match Timer with Locking Watchdog

The block is a free-running up-counter shared by four compare channels. Software programs a compare value per channel over a small word-addressed register bus. When the counter equals a channel's compare value, that channel's status flag latches and stays set until software clears it. Each flag is gated by a per-channel enable bit to form that channel's interrupt line.

The highest channel doubles as a watchdog. Once software arms the watchdog, a hit on that channel produces a one-cycle reset request for the system reset controller. Arming is one-way: only the block's own reset returns it to the disarmed state. Software services the watchdog by moving the last channel's compare value ahead of the counter before the counter reaches it.

The watchdog is a small state machine with three states:
- WD_IDLE is the disarmed state. Transition IDLE_TO_ARMED is taken on a write of 1 to bit 0 of the arm register.
- WD_ARMED waits for a hit on the last channel. Transition ARMED_TO_FIRE is taken on that hit.
- WD_FIRE drives the reset request for one cycle. Transition FIRE_TO_ARMED is taken unconditionally on the next edge.

No transition leads back to WD_IDLE except reset.

Top module: `mt_match_timer`

## Requirements
- R1: After reset, every compare register reads 0xFFFFFFFF, and status, interrupt enable and the arm bit read 0. irq and rst_req are low.
- R2: The counter advances by exactly one on every clock edge where it is not written, and wraps from 0xFFFFFFFF to 0.
- R3: A write to byte offset 0x10 loads the counter. The written value reads back in the following cycle, and counting resumes from it.
- R4: Status bit n (offset 0x14) becomes 1 on the edge where the counter equals compare register n. The comparison is exact equality, and the bit stays 1 while no clear is written.
- R5: Writing status with bit n = 1 clears bit n, and bit n = 0 leaves it unchanged. If a hit on channel n arrives on the same edge as the clearing write, the bit stays 1.
- R6: irq[n] is high exactly when status bit n and interrupt-enable bit n (offset 0x1C, bit n) are both 1.
- R7: Writing offset 0x18 with bit 0 = 1 arms the watchdog. Writing 0 has no effect. The arm state reads back at bit 0 of offset 0x18, and only reset clears it.
- R8: While armed, a hit on channel 3 raises rst_req for exactly one cycle, in the same cycle that status bit 3 first reads 1. While disarmed, rst_req stays low.
- R9: A compare value written below the current counter value produces no hit until the counter wraps around and reaches it.
- R10: Compare register n is at byte offset 4*n. A write or read with nonzero address bits [1:0] is ignored and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (5) | Byte address of the register accessed |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for bus_addr, combinational |
| irq | output | NCH (4) | Per-channel interrupt lines |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The bench builds the block with its defaults: four channels, a 32-bit counter and a 5-bit address. At these values every register offset in the map is decoded, and channel 3 is the watchdog. Because the counter is writable, the bench can preload it just below 0xFFFFFFFF, which brings the wrap and the "already passed" compare case within a few hundred cycles. Reaching them by counting from zero would take 2^32 cycles.

// File: rtl/mt_pkg.sv
package mt_pkg;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRE  = 2'd2
    } wd_state_e;

endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else begin
            cnt_q <= cnt_q + STEP;
        end
    end

endmodule

// File: rtl/mt_match_bank.sv
module mt_match_bank #(
    parameter int NCH   = 4,
    parameter int CNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CNT_W-1:0]          cnt_q,
    input  logic [NCH-1:0]            cmp_wr,
    input  logic [CNT_W-1:0]          wdata,
    input  logic [NCH-1:0]            clr_mask,
    output logic [NCH-1:0][CNT_W-1:0] cmp_q,
    output logic [NCH-1:0]            hit,
    output logic [NCH-1:0]            sts_q
);

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic [CNT_W-1:0] cmp_r;
        logic             flag_r;
        logic             eq;

        assign eq = (cnt_q == cmp_r);

        // compare value register
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_r <= '1;
            end else if (cmp_wr[n]) begin
                cmp_r <= wdata;
            end
        end

        // sticky flag: a new hit outranks a clear on the same edge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_r <= 1'b0;
            end else begin
                flag_r <= eq | (flag_r & ~clr_mask[n]);
            end
        end

        assign cmp_q[n] = cmp_r;
        assign hit[n]   = eq;
        assign sts_q[n] = flag_r;
    end

endmodule

// File: rtl/mt_wdog_fsm.sv
module mt_wdog_fsm
    import mt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_wr,
    input  logic arm_bit,
    input  logic wd_hit,
    output logic armed,
    output logic rst_req
);

    wd_state_e state_q;
    wd_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:  if (arm_wr && arm_bit) state_d = WD_ARMED;  // IDLE_TO_ARMED
            WD_ARMED: if (wd_hit)            state_d = WD_FIRE;   // ARMED_TO_FIRE
            WD_FIRE:                         state_d = WD_ARMED;  // FIRE_TO_ARMED
            default:                         state_d = WD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        armed   = 1'b0;
        rst_req = 1'b0;
        unique case (state_q)
            WD_IDLE:  ;
            WD_ARMED: armed = 1'b1;
            WD_FIRE: begin
                armed   = 1'b1;
                rst_req = 1'b1;
            end
            default:  ;
        endcase
    end

endmodule

// File: rtl/mt_match_timer.sv
module mt_match_timer #(
    parameter int NCH    = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    irq,
    output logic              rst_req
);

    localparam int               IDX_W   = ADDR_W - 2;
    localparam int               WD_CH   = NCH - 1;
    localparam logic [IDX_W-1:0] IDX_CNT = IDX_W'(NCH);
    localparam logic [IDX_W-1:0] IDX_STS = IDX_W'(NCH + 1);
    localparam logic [IDX_W-1:0] IDX_ARM = IDX_W'(NCH + 2);
    localparam logic [IDX_W-1:0] IDX_IEN = IDX_W'(NCH + 3);

    logic [IDX_W-1:0]          idx;
    logic                      aligned;
    logic                      wr_ok;
    logic [NCH-1:0]            cmp_wr;
    logic [NCH-1:0]            clr_mask;
    logic [NCH-1:0][CNT_W-1:0] cmp_q;
    logic [NCH-1:0]            hit;
    logic [NCH-1:0]            sts_q;
    logic [NCH-1:0]            ien_q;
    logic [CNT_W-1:0]          cnt_q;
    logic                      armed;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_ok   = bus_wr && aligned;

    for (genvar n = 0; n < NCH; n++) begin : g_dec
        assign cmp_wr[n] = wr_ok && (idx == IDX_W'(n));
    end

    assign clr_mask = (wr_ok && idx == IDX_STS) ? bus_wdata[NCH-1:0] : '0;

    mt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_ok && idx == IDX_CNT),
        .load_val (bus_wdata),
        .cnt_q    (cnt_q)
    );

    mt_match_bank #(.NCH(NCH), .CNT_W(CNT_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_q    (cnt_q),
        .cmp_wr   (cmp_wr),
        .wdata    (bus_wdata),
        .clr_mask (clr_mask),
        .cmp_q    (cmp_q),
        .hit      (hit),
        .sts_q    (sts_q)
    );

    mt_wdog_fsm u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_wr  (wr_ok && idx == IDX_ARM),
        .arm_bit (bus_wdata[0]),
        .wd_hit  (hit[WD_CH]),
        .armed   (armed),
        .rst_req (rst_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (wr_ok && idx == IDX_IEN) begin
            ien_q <= bus_wdata[NCH-1:0];
        end
    end

    assign irq = sts_q & ien_q;

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            for (int n = 0; n < NCH; n++) begin
                if (idx == IDX_W'(n)) bus_rdata = cmp_q[n];
            end
            if (idx == IDX_CNT) bus_rdata = cnt_q;
            if (idx == IDX_STS) bus_rdata = CNT_W'(sts_q);
            if (idx == IDX_ARM) bus_rdata = CNT_W'(armed);
            if (idx == IDX_IEN) bus_rdata = CNT_W'(ien_q);
        end
    end

endmodule

// File: rtl/mt_match_timer_chk.sv
module mt_match_timer_chk #(
    parameter int NCH    = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic [NCH-1:0]    irq,
    input logic              rst_req,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [NCH-1:0]    sts_q,
    input logic [NCH-1:0]    ien_q,
    input logic              armed
);

    logic           cnt_wr;
    logic [NCH-1:0] clr_seen;

    assign cnt_wr   = bus_wr && (bus_addr == ADDR_W'(4 * NCH));
    assign clr_seen = (bus_wr && bus_addr == ADDR_W'(4 * NCH + 4)) ? bus_wdata[NCH-1:0] : '0;

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cnt_wr)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    p_cnt_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cnt_wr)) |-> (cnt_q == $past(bus_wdata)));

    p_sts_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(sts_q) & ~$past(clr_seen)) & ~sts_q) == '0));

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> (irq == '0));

    p_arm_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(armed)) |-> armed);

    p_rst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_rst_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (armed && sts_q[NCH-1]));

endmodule

bind mt_match_timer mt_match_timer_chk #(
    .NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .rst_req   (rst_req),
    .cnt_q     (cnt_q),
    .sts_q     (sts_q),
    .ien_q     (ien_q),
    .armed     (armed)
);

// File: tb/mt_match_timer_tb_top.sv
module mt_match_timer_tb_top;

    localparam int NCH    = 4;
    localparam int CNT_W  = 32;
    localparam int ADDR_W = 5;

    localparam logic [4:0] A_CNT = 5'h10;
    localparam logic [4:0] A_STS = 5'h14;
    localparam logic [4:0] A_ARM = 5'h18;
    localparam logic [4:0] A_IEN = 5'h1C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [CNT_W-1:0]  bus_wdata = '0;
    logic [CNT_W-1:0]  bus_rdata;
    logic [NCH-1:0]    irq;
    logic              rst_req;

    always #2 clk = ~clk;

    mt_match_timer #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .rst_req   (rst_req)
    );

    // ---------------- reference model built from the requirements ----------------
    logic [CNT_W-1:0] m_cnt;
    logic [CNT_W-1:0] m_cmp [NCH];
    logic [NCH-1:0]   m_sts, m_ien, m_hit;
    logic             m_arm, m_rst;

    always_comb begin
        for (int n = 0; n < NCH; n++) m_hit[n] = (m_cnt == m_cmp[n]);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= '0;
            for (int n = 0; n < NCH; n++) m_cmp[n] <= '1;
            m_sts <= '0; m_ien <= '0; m_arm <= 1'b0; m_rst <= 1'b0;
        end else begin
            logic ok;
            ok = bus_wr && bus_addr[1:0] == 2'b00;
            m_sts <= m_hit | (m_sts & ~((ok && bus_addr == A_STS) ? bus_wdata[NCH-1:0] : '0));
            m_cnt <= (ok && bus_addr == A_CNT) ? bus_wdata : m_cnt + 1;
            for (int n = 0; n < NCH; n++)
                if (ok && bus_addr == 5'(4 * n)) m_cmp[n] <= bus_wdata;
            if (ok && bus_addr == A_IEN) m_ien <= bus_wdata[NCH-1:0];
            if (ok && bus_addr == A_ARM && bus_wdata[0]) m_arm <= 1'b1;
            m_rst <= m_arm && m_hit[NCH-1] && !m_rst;
        end
    end

    function automatic logic [CNT_W-1:0] exp_rd(logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00) return '0;
        case (a[4:2])
            3'd4: return m_cnt;
            3'd5: return CNT_W'(m_sts);
            3'd6: return CNT_W'(m_arm);
            3'd7: return CNT_W'(m_ien);
            default: return m_cmp[a[3:2]];
        endcase
    endfunction

    // ---------------- checking ----------------
    int  total = 0;
    int  bad = 0;
    bit  run_cmp = 1'b0;
    bit  finished = 1'b0;

    task automatic check(bit ok, string req, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // continuous comparison against the model, one step after each falling edge
    always @(negedge clk) begin
        #1;
        if (rst_n && run_cmp) begin
            check(irq == (m_sts & m_ien), "R6 irq", CNT_W'(irq), CNT_W'(m_sts & m_ien));
            check(rst_req == m_rst, "R8 rst_req", CNT_W'(rst_req), CNT_W'(m_rst));
            check(bus_rdata == exp_rd(bus_addr), "R10 rdata", bus_rdata, exp_rd(bus_addr));
        end
    end

    task automatic wr(logic [4:0] a, logic [CNT_W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
    endtask

    task automatic rd(logic [4:0] a, output logic [CNT_W-1:0] v);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            bus_wr = 1'b0;
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [CNT_W-1:0] v, v2;
        int pulses;
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        for (int n = 0; n < NCH; n++) begin
            rd(5'(4 * n), v);
            check(v == 32'hFFFF_FFFF, "R1 cmp reset", v, 32'hFFFF_FFFF);
        end
        rd(A_STS, v); check(v == 0, "R1 sts reset", v, 0);
        rd(A_IEN, v); check(v == 0, "R1 ien reset", v, 0);
        rd(A_ARM, v); check(v == 0, "R1 arm reset", v, 0);
        check(irq == 0 && rst_req == 0, "R1 outputs", {irq, rst_req}, 0);
        run_cmp = 1'b1;

        // R2 step and wrap, R3 load
        rd(A_CNT, v); rd(A_CNT, v2);
        check(v2 == v + 1, "R2 step", v2, v + 1);
        wr(A_CNT, 32'hFFFF_FFFE);
        rd(A_CNT, v); check(v == 32'hFFFF_FFFE, "R3 load", v, 32'hFFFF_FFFE);
        rd(A_CNT, v); check(v == 32'hFFFF_FFFF, "R2 top", v, 32'hFFFF_FFFF);
        rd(A_CNT, v); check(v == 32'h0, "R2 wrap", v, 0);
        wr(A_STS, 32'hF);

        // R10 offsets and misaligned access
        for (int n = 0; n < NCH; n++) wr(5'(4 * n), 32'hA000_0000 + 32'(n));
        for (int n = 0; n < NCH; n++) begin
            rd(5'(4 * n), v);
            check(v == 32'hA000_0000 + 32'(n), "R10 cmp offset", v, 32'hA000_0000 + 32'(n));
        end
        wr(5'h1D, 32'hF);
        rd(A_IEN, v); check(v == 0, "R10 misaligned write", v, 0);
        rd(5'h1E, v); check(v == 0, "R10 misaligned read", v, 0);

        // R4 sticky status with exact hit
        rd(A_CNT, v);
        wr(5'h08, v + 21);
        idle(10);
        rd(A_STS, v); check(v[2] == 1'b0, "R4 before hit", v, 0);
        idle(20);
        rd(A_STS, v); check(v[2] == 1'b1, "R4 hit", v, 4);
        idle(40);
        rd(A_STS, v); check(v[2] == 1'b1, "R4 sticky", v, 4);

        // R6 interrupt gating
        wr(A_IEN, 32'h4);
        rd(A_IEN, v);
        check(irq == 4'b0100, "R6 irq on", CNT_W'(irq), 4);
        wr(A_IEN, 32'h0);
        rd(A_IEN, v);
        check(irq == 4'b0000, "R6 irq off", CNT_W'(irq), 0);

        // R5 write-1-clear, write-0 keep, hit beats clear
        wr(A_STS, 32'h0);
        rd(A_STS, v); check(v[2] == 1'b1, "R5 zero keeps", v, 4);
        wr(A_STS, 32'h4);
        rd(A_STS, v); check(v[2] == 1'b0, "R5 clear", v, 0);
        wr(5'h00, 32'd1000);
        wr(A_STS, 32'h1);
        wr(A_CNT, 32'd1000);
        wr(A_STS, 32'h1);
        rd(A_STS, v); check(v[0] == 1'b1, "R5 hit beats clear", v, 1);
        wr(A_STS, 32'h1);
        rd(A_STS, v); check(v[0] == 1'b0, "R5 clear after", v, 0);

        // R9 compare value already passed
        wr(5'h04, 32'd50);
        wr(A_CNT, 32'd100);
        wr(A_STS, 32'h2);
        idle(100);
        rd(A_STS, v); check(v[1] == 1'b0, "R9 passed no hit", v, 0);
        wr(A_CNT, 32'hFFFF_FF00);
        idle(320);
        rd(A_STS, v); check(v[1] == 1'b1, "R9 hit after wrap", v, 2);

        // R8 disarmed: no request on channel 3 hit
        wr(A_STS, 32'hF);
        rd(A_CNT, v);
        wr(5'h0C, v + 12);
        pulses = 0;
        repeat (30) begin idle(1); if (rst_req) pulses++; end
        check(pulses == 0, "R8 disarmed", pulses, 0);

        // R7 arm, write 0 ignored
        wr(A_ARM, 32'h1);
        rd(A_ARM, v); check(v == 1, "R7 armed", v, 1);
        wr(A_ARM, 32'h0);
        rd(A_ARM, v); check(v == 1, "R7 zero ignored", v, 1);

        // R8 armed: single pulse
        rd(A_CNT, v);
        wr(5'h0C, v + 12);
        pulses = 0;
        repeat (30) begin idle(1); if (rst_req) pulses++; end
        check(pulses == 1, "R8 one pulse", pulses, 1);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            int op;
            int ch;
            op = int'($urandom % 16);
            ch = int'($urandom % NCH);
            case (op)
                0, 1, 2: wr(5'(4 * ch), m_cnt + ($urandom % 24));
                3:       wr(A_IEN, $urandom);
                4, 5:    wr(A_STS, $urandom);
                6:       wr(A_CNT, m_cmp[ch] - ($urandom % 8));
                7:       wr(A_ARM, $urandom);
                8:       wr(5'($urandom), $urandom);
                default: rd(5'($urandom), v);
            endcase
        end
        idle(4);
        summary();
    end

endmodule